// File: doc/BRIEF.md
# Dual-Thread Decoupling Micro-op Queue

This block sits between a shared decode stage and a single-issue execution stage in a core that runs two hardware threads at once. Each thread has its own private queue of decoded micro-operations. In one cycle, decode can hand over up to two operations. Both can belong to one thread, or there can be one for each thread. In one cycle, execution takes at most one operation, and a round-robin picker chooses which thread supplies it.

Decode uses the per-thread stall, full and occupancy outputs to pace itself. A write aimed at a thread whose queue lacks room for the whole cycle's batch is refused in full. A per-thread flush input discards one thread's pending work, for example after a mispredict, and leaves the other thread untouched.

Top module: `dual_thread_uop_queue`

## Requirements
- R1: While the synchronous active-low reset is asserted, and in the first cycle after it, both queues are empty: both occupancy outputs read 0 and `iss_valid` is 0.
- R2: Each thread owns `DEPTH` (default 16) entries. `count0` and `count1` report occupancy from 0 to `DEPTH`. `full[t]` is 1 exactly when thread t holds `DEPTH` entries.
- R3: Both write ports may target the same thread or different threads in one cycle. Thread ID encoding is 0 for thread 0 and 1 for thread 1. When both ports target one thread, the port-0 operation is older and issues first.
- R4: `stall[t]` is high in a cycle when the number of valid writes aimed at thread t exceeds the free slots held at the start of that cycle. An issue in the same cycle does not count as a free slot. When `stall[t]` is high, none of those writes enters the queue.
- R5: At most one operation issues per cycle. `iss_valid` is high when at least one thread has a non-empty queue and is not being flushed. `iss_data` is the oldest entry of the thread named by `iss_tid`.
- R6: When both threads are eligible, the thread that did not issue last is chosen, and thread 0 wins the first such tie after reset. When only one thread is eligible, it is chosen in that same cycle.
- R7: While `iss_ready` is low, no entry is removed and the round-robin choice does not change.
- R8: An operation written in a cycle is not offered on the issue port in that same cycle.
- R9: A flush of thread t empties its queue in one cycle and wins over writes to t in that cycle. The thread is not offered for issue during that cycle. The other thread's contents and order are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr0_valid | input | 1 | Write port 0 carries an operation |
| wr0_tid | input | 1 | Thread of port 0 operation |
| wr0_data | input | PAYLOAD_W | Port 0 payload |
| wr1_valid | input | 1 | Write port 1 carries an operation |
| wr1_tid | input | 1 | Thread of port 1 operation |
| wr1_data | input | PAYLOAD_W | Port 1 payload |
| flush | input | 2 | Per-thread flush, bit t for thread t |
| stall | output | 2 | Per-thread write refusal this cycle |
| full | output | 2 | Per-thread queue full |
| count0 | output | $clog2(DEPTH+1) | Thread 0 occupancy |
| count1 | output | $clog2(DEPTH+1) | Thread 1 occupancy |
| iss_valid | output | 1 | An operation is offered to execution |
| iss_ready | input | 1 | Execution accepts the offered operation |
| iss_tid | output | 1 | Thread of the offered operation |
| iss_data | output | PAYLOAD_W | Offered payload |

## Verification
The embedded assertions watch several rules on every cycle. Occupancy never exceeds the depth. A flush leaves an empty queue on the next cycle. No pop is taken from an empty queue. A stalled thread's occupancy never grows. The picker alternates under contention and holds its state while ready is low. Payload ordering cannot be shown by these per-cycle rules. Only the bench's scenarios, checked against a behavioural queue model, can show port-0-first order within a pair, the exact all-or-nothing refusal at 15 of 16 entries, the absence of write-to-issue bypass, and the isolation of the other thread across a flush.

// File: rtl/tq_pkg.sv
// Shared constants for the dual-thread micro-op queue.
package tq_pkg;
    localparam int NUM_THR = 2;   // hardware threads served by the queue
    localparam int TID_W   = 1;   // width of a thread identifier
endpackage

// File: rtl/tq_thread_fifo.sv
// One thread's circular micro-op buffer. It accepts 0, 1 or 2 pushes per
// cycle (first then second), at most one pop, and a one-cycle flush.
// Assumes: DEPTH is a power of two. The caller only pushes what fits and
// only pops when non-empty.
module tq_thread_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [1:0]    push_n,
    input  logic [W-1:0]  d_first,
    input  logic [W-1:0]  d_second,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;

    initial begin
        depth_pow2_chk: assert ((DEPTH & (DEPTH - 1)) == 0 && DEPTH >= 2);
    end

    assign head = mem[rd_ptr];

    // Storage write: the older op goes at the tail, the younger one after it.
    always_ff @(posedge clk) begin
        if (!flush && push_n != 2'd0) mem[wr_ptr] <= d_first;
        if (!flush && push_n == 2'd2) mem[wr_ptr + AW'(1)] <= d_second;
    end

    // Pointer and occupancy update; flush wins over push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            rd_ptr <= rd_ptr + AW'(pop);
            wr_ptr <= wr_ptr + AW'(push_n);
            count  <= count + CW'(push_n) - CW'(pop);
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/tq_rr_arb.sv
// Two-way round-robin picker. It grants the eligible thread, or on a tie
// the one that did not issue last. Its state moves only on an accepted issue.
// Assumes: elig is already masked for flushes.
module tq_rr_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] elig,
    input  logic       ready,
    output logic       valid,
    output logic       gnt
);
    logic last;

    // Grant selection: alternate on a tie, otherwise take the only candidate.
    always_comb begin
        valid = |elig;
        gnt   = (elig == 2'b11) ? ~last : elig[1];
    end

    // Remember the last issuing thread; reset makes thread 0 win first.
    always_ff @(posedge clk) begin
        if (!rst_n)              last <= 1'b1;
        else if (valid && ready) last <= gnt;
    end

    // R7
    hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(last));
    // R6
    rr_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == 2'b11 && ready) |=> (last != $past(last)));
endmodule

// File: rtl/dual_thread_uop_queue.sv
// Decoupling queue between a shared two-wide decode and a one-wide issue in
// a two-thread core. Writes are steered to per-thread buffers with
// all-or-nothing acceptance, and one operation issues per cycle by round-robin.
// Assumes: decode honours stall. Flushed work is discarded silently.
module dual_thread_uop_queue
    import tq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PAYLOAD_W = 32,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr0_valid,
    input  logic                 wr0_tid,
    input  logic [PAYLOAD_W-1:0] wr0_data,
    input  logic                 wr1_valid,
    input  logic                 wr1_tid,
    input  logic [PAYLOAD_W-1:0] wr1_data,
    input  logic [1:0]           flush,
    output logic [1:0]           stall,
    output logic [1:0]           full,
    output logic [CW-1:0]        count0,
    output logic [CW-1:0]        count1,
    output logic                 iss_valid,
    input  logic                 iss_ready,
    output logic                 iss_tid,
    output logic [PAYLOAD_W-1:0] iss_data
);
    logic [CW-1:0]        cnt  [NUM_THR];
    logic [PAYLOAD_W-1:0] head [NUM_THR];
    logic [1:0]           elig, pop;
    logic                 gnt;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        logic       sel0, sel1;
        logic [1:0] req_n, push_n;
        logic [CW-1:0] free_slots;

        // Steering: count the requests for this thread and check room for all.
        always_comb begin
            sel0       = wr0_valid && (wr0_tid == TID_W'(t));
            sel1       = wr1_valid && (wr1_tid == TID_W'(t));
            req_n      = {1'b0, sel0} + {1'b0, sel1};
            free_slots = CW'(DEPTH) - cnt[t];
            stall[t]   = CW'(req_n) > free_slots;
            push_n     = (!flush[t] && !stall[t]) ? req_n : 2'd0;
            full[t]    = (cnt[t] == CW'(DEPTH));
            elig[t]    = (cnt[t] != '0) && !flush[t];
            pop[t]     = iss_valid && iss_ready && (gnt == TID_W'(t));
        end

        tq_thread_fifo #(.DEPTH(DEPTH), .W(PAYLOAD_W)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush[t]),
            .push_n   (push_n),
            .d_first  (sel0 ? wr0_data : wr1_data),
            .d_second (wr1_data),
            .pop      (pop[t]),
            .head     (head[t]),
            .count    (cnt[t])
        );

        // R4
        stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stall[t] |=> (cnt[t] <= $past(cnt[t])));
    end

    tq_rr_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .ready (iss_ready),
        .valid (iss_valid),
        .gnt   (gnt)
    );

    // Issue port and occupancy outputs.
    always_comb begin
        iss_tid  = gnt;
        iss_data = head[gnt];
        count0   = cnt[0];
        count1   = cnt[1];
    end

    // R5
    one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pop) <= 1);
endmodule

// File: tb/tb_dual_thread_uop_queue.sv
module tb_dual_thread_uop_queue;
    localparam int DEPTH = 16;
    localparam int W     = 32;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic wr0_valid, wr0_tid, wr1_valid, wr1_tid, iss_ready;
    logic [W-1:0] wr0_data, wr1_data, iss_data;
    logic [1:0] flush, stall, full;
    logic [CW-1:0] count0, count1;
    logic iss_valid, iss_tid;

    int n_chk = 0, n_fail = 0;
    logic [W-1:0] mq [2][$];
    logic last_rr;
    logic [W-1:0] seq = 32'h100;

    always #2 clk = ~clk;

    dual_thread_uop_queue #(.DEPTH(DEPTH), .PAYLOAD_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr0_valid(wr0_valid), .wr0_tid(wr0_tid), .wr0_data(wr0_data),
        .wr1_valid(wr1_valid), .wr1_tid(wr1_tid), .wr1_data(wr1_data),
        .flush(flush), .stall(stall), .full(full),
        .count0(count0), .count1(count1),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_tid(iss_tid), .iss_data(iss_data)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare against the model, clock, advance the model.
    task automatic step(input string tag, input logic v0, input logic t0,
                        input logic v1, input logic t1, input logic [1:0] fl,
                        input logic rdy);
        int n [2];
        logic [1:0] est, acc, el;
        logic ev, etid;
        logic [W-1:0] d0, d1;
        @(negedge clk);
        d0 = seq; d1 = seq + 1; seq = seq + 2;
        wr0_valid = v0; wr0_tid = t0; wr0_data = d0;
        wr1_valid = v1; wr1_tid = t1; wr1_data = d1;
        flush = fl; iss_ready = rdy;
        #1;
        for (int t = 0; t < 2; t++) begin
            n[t]   = int'(v0 && t0 == t) + int'(v1 && t1 == t);
            est[t] = n[t] > (DEPTH - mq[t].size());
            acc[t] = !fl[t] && !est[t];
            el[t]  = (mq[t].size() > 0) && !fl[t];
        end
        ev   = |el;
        etid = (el == 2'b11) ? ~last_rr : el[1];
        check({tag, " R2 count0"}, W'(count0), W'(mq[0].size()));
        check({tag, " R2 count1"}, W'(count1), W'(mq[1].size()));
        check({tag, " R2 full"}, W'(full), W'({mq[1].size() == DEPTH, mq[0].size() == DEPTH}));
        check({tag, " R4 stall"}, W'(stall), W'(est));
        check({tag, " R5 iss_valid"}, W'(iss_valid), W'(ev));
        if (ev) begin
            check({tag, " R6 iss_tid"}, W'(iss_tid), W'(etid));
            check({tag, " R5 iss_data"}, iss_data, mq[etid][0]);
        end
        @(posedge clk);
        if (ev && rdy) begin
            void'(mq[etid].pop_front());
            last_rr = etid;
        end
        for (int t = 0; t < 2; t++) begin
            if (fl[t]) mq[t].delete();
            else if (acc[t]) begin
                if (v0 && t0 == t) mq[t].push_back(d0);
                if (v1 && t1 == t) mq[t].push_back(d1);
            end
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        last_rr = 1'b1;
        rst_n = 1'b0;
        wr0_valid = 1; wr0_tid = 0; wr0_data = 1;
        wr1_valid = 1; wr1_tid = 1; wr1_data = 2;
        flush = 0; iss_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: writes during reset are not kept
        check("R1 reset count0", W'(count0), 0);
        check("R1 reset count1", W'(count1), 0);
        check("R1 reset iss_valid", W'(iss_valid), 0);
        rst_n = 1'b1;
        wr0_valid = 0; wr1_valid = 0;
        step("R1 first", 0, 0, 0, 0, 2'b00, 1);

        // R8: a write is not visible on the issue port in its own cycle
        step("R8 write", 1, 0, 0, 0, 2'b00, 1);
        step("R8 drain", 0, 0, 0, 0, 2'b00, 1);

        // R3: pair to thread 1, port 0 must drain first
        step("R3 pair", 1, 1, 1, 1, 2'b00, 0);
        step("R3 first", 0, 0, 0, 0, 2'b00, 1);
        step("R3 second", 0, 0, 0, 0, 2'b00, 1);

        // R4 and R2: fill thread 0 to 15, refuse a pair, then fill to 16
        for (int i = 0; i < 7; i++) step("R2 fill", 1, 0, 1, 0, 2'b00, 0);
        step("R2 fill", 1, 0, 0, 0, 2'b00, 0);
        step("R4 pair at 15", 1, 0, 1, 0, 2'b00, 0);
        step("R4 split", 1, 0, 1, 1, 2'b00, 0);
        step("R2 full", 1, 0, 0, 0, 2'b00, 0);
        step("R4 at 16", 0, 0, 1, 0, 2'b00, 0);

        // R7: ready low keeps everything
        for (int i = 0; i < 3; i++) step("R7 hold", 0, 0, 0, 0, 2'b00, 0);

        // R6: alternate between threads
        step("R6 feed", 1, 1, 1, 1, 2'b00, 1);
        for (int i = 0; i < 6; i++) step("R6 alt", 0, 0, 0, 0, 2'b00, 1);

        // R9: flush thread 0 while writing both threads
        step("R9 flush", 1, 0, 1, 1, 2'b01, 1);
        step("R9 after", 0, 0, 0, 0, 2'b00, 0);
        step("R9 flush1", 1, 1, 0, 0, 2'b10, 1);
        step("R9 after1", 0, 0, 0, 0, 2'b00, 1);

        // Mixed random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] fl;
            fl = {($urandom % 24) == 0, ($urandom % 24) == 0};
            step("RND R6", 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 fl, ($urandom % 4) != 0);
        end
        finish_run();
    end
endmodule